// File: doc/BRIEF.md
# Programmable Duty Pulse Channel

This block produces a square-wave tone at a fixed level. A 12-bit period value sets a countdown divider. Each time the divider runs out, a 16-position step counter moves on by one. The output shows the programmed 4-bit volume while the step counter sits at or below a 3-bit duty threshold, and shows zero for the rest of the sequence. A flag in the shape register can force the volume out for every step. The block advances only on cycles where the clock-enable input `tick` is high. Normally `tick` pulses once per processor cycle.

Software programs the channel through one byte-wide write port. A 2-bit select picks one of four byte registers: the tone shape, the low period byte, the high period nibble with the enable, and a shared audio-control byte. The control byte holds a halt flag and a divider right-shift of 0, 4 or 8 bits. Every channel of a wider sound unit would share that shift. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `pulse_tone_channel`

## Requirements
- R1: After reset the channel is disabled, the output is 0, the step is 0, halt is off, the shift is 0, the shape register is 0 and the period is 1. Enabling with only the shape register written therefore gives a reload of 2 ticks per step.
- R2: Select 0 is the shape register: volume in data bits 3:0, duty threshold in bits 6:4, duty-ignore flag in bit 7.
- R3: Select 1 loads period bits 7:0. Select 2 loads period bits 11:8 from data bits 3:0 and the enable from data bit 7.
- R4: While the enable is 0 the output is 0. A select-2 write with bit 7 clear returns the step to 0, so the next enable starts at step 0.
- R5: While enabled, not halted and `tick` is high, the divider counts down by one. When it would reach zero, the step advances modulo 16 and the divider reloads with (period >> shift) + 1. One step lasts R = (period >> shift) + 1 ticks, and a full wave lasts 16·R ticks.
- R6: The output equals the volume when enabled and either the duty-ignore flag is set or step ≤ duty. Otherwise the output is 0. The high time is therefore (duty+1)·R ticks.
- R7: Select 3 is the shared control register. Bit 0 halts the channel. Bit 2 selects a shift of 8. Otherwise bit 1 selects a shift of 4. Otherwise the shift is 0. Bit 2 wins over bit 1.
- R8: While halted, neither the divider nor the step changes, so the output holds its level.
- R9: On cycles with `tick` low, neither the divider nor the step changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable, one pulse per processor cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 shape, 1 period low, 2 period high/enable, 3 shared control |
| wr_data | input | 8 | Write data byte |
| level | output | 4 | Output level |

## Verification
The bench sweeps all eight duty thresholds under four control settings: shift 0, shift 4, shift 8, and both shift bits set. For each run it measures high and low run lengths and compares them with (duty+1)·R and (15−duty)·R. Wrong duty comparison, wrong step wrap and wrong shift priority therefore each show up as different numbers. A run with `tick` at half rate separates tick gating from free-running counting. Holding tests for halt, for `tick` held low and for the duty-ignore flag show that the output stays at the value it had after the write. A disable/re-enable sequence with duty 0 shows that the step returns to 0, because a step that was not cleared would leave the output low.

// File: rtl/pulse_pkg.sv
package pulse_pkg;

  localparam int PER_W   = 12;            // period width
  localparam int CNT_W   = PER_W + 1;     // divider holds up to 2^PER_W
  localparam int STEP_W  = 4;             // 16-step sequence
  localparam int DUTY_W  = 3;
  localparam int VOL_W   = 4;
  localparam int SH_W    = 4;
  localparam int SHIFT_MID = 4;
  localparam int SHIFT_HI  = 8;
  localparam int HI_W    = PER_W - 8;     // period bits carried in select 2

  typedef enum logic [1:0] {
    SEL_SHAPE = 2'd0,
    SEL_PLO   = 2'd1,
    SEL_PHI   = 2'd2,
    SEL_CTRL  = 2'd3
  } sel_e;

  // field order matches the shape byte: ignore, duty, volume
  typedef struct packed {
    logic              ign;
    logic [DUTY_W-1:0] duty;
    logic [VOL_W-1:0]  vol;
  } shape_t;

  function automatic logic [SH_W-1:0] shift_sel(input logic hi, input logic mid);
    if (hi)       return SH_W'(SHIFT_HI);
    else if (mid) return SH_W'(SHIFT_MID);
    else          return '0;
  endfunction

  function automatic logic [CNT_W-1:0] reload_of(input logic [PER_W-1:0] p,
                                                 input logic [SH_W-1:0] sh);
    logic [CNT_W-1:0] ext;
    ext = {1'b0, p} >> sh;
    return ext + 1'b1;
  endfunction

  function automatic logic [VOL_W-1:0] gate_level(input logic en, input shape_t s,
                                                  input logic [STEP_W-1:0] st);
    if (en && (s.ign || (st <= STEP_W'(s.duty)))) return s.vol;
    else                                          return '0;
  endfunction

endpackage

// File: rtl/pulse_regs.sv
module pulse_regs
  import pulse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  output shape_t            shape,
  output logic [PER_W-1:0]  period,
  output logic              enable,
  output logic              halt,
  output logic [SH_W-1:0]   shift,
  output logic              seq_clear
);

  assign seq_clear = wr_en && (sel_e'(wr_sel) == SEL_PHI) && !wr_data[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shape  <= '0;
      period <= PER_W'(1);
      enable <= 1'b0;
      halt   <= 1'b0;
      shift  <= '0;
    end else if (wr_en) begin
      case (sel_e'(wr_sel))
        SEL_SHAPE: shape <= shape_t'(wr_data);
        SEL_PLO:   period[7:0] <= wr_data;
        SEL_PHI: begin
          period[PER_W-1:8] <= wr_data[HI_W-1:0];
          enable            <= wr_data[7];
        end
        default: begin
          halt  <= wr_data[0];
          shift <= shift_sel(wr_data[2], wr_data[1]);
        end
      endcase
    end
  end

endmodule

// File: rtl/pulse_divider.sv
module pulse_divider
  import pulse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              enable,
  input  logic              halt,
  input  logic              seq_clear,
  input  logic [PER_W-1:0]  period,
  input  logic [SH_W-1:0]   shift,
  output logic [STEP_W-1:0] step,
  output logic [CNT_W-1:0]  timer,
  output logic              adv
);

  logic run;
  assign run = tick && enable && !halt;
  assign adv = run && (timer == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step  <= '0;
      timer <= CNT_W'(1);
    end else begin
      if (seq_clear)  step <= '0;
      else if (adv)   step <= step + 1'b1;
      if (run) timer <= adv ? reload_of(period, shift) : timer - 1'b1;
    end
  end

endmodule

// File: rtl/pulse_gate.sv
module pulse_gate
  import pulse_pkg::*;
(
  input  logic              enable,
  input  shape_t            shape,
  input  logic [STEP_W-1:0] step,
  output logic [VOL_W-1:0]  level
);

  always_comb level = gate_level(enable, shape, step);

endmodule

// File: rtl/pulse_tone_channel.sv
module pulse_tone_channel
  import pulse_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [3:0] level
);

  shape_t             shape;
  logic [PER_W-1:0]   period;
  logic               enable;
  logic               halt;
  logic [SH_W-1:0]    shift;
  logic               seq_clear;
  logic [STEP_W-1:0]  step;
  logic [CNT_W-1:0]   timer;
  logic               adv;

  pulse_regs u_regs (
    .clk, .rst_n, .wr_en, .wr_sel, .wr_data,
    .shape, .period, .enable, .halt, .shift, .seq_clear
  );

  pulse_divider u_div (
    .clk, .rst_n, .tick, .enable, .halt, .seq_clear,
    .period, .shift, .step, .timer, .adv
  );

  pulse_gate u_gate (
    .enable, .shape, .step, .level
  );

endmodule

// File: rtl/pulse_tone_channel_chk.sv
module pulse_tone_channel_chk
  import pulse_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              enable,
  input logic              halt,
  input logic              seq_clear,
  input logic              adv,
  input logic [STEP_W-1:0] step,
  input logic [CNT_W-1:0]  timer,
  input logic [PER_W-1:0]  period,
  input logic [SH_W-1:0]   shift,
  input logic [VOL_W-1:0]  vol,
  input logic [VOL_W-1:0]  level
);

  // R5
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !seq_clear) |=> step == STEP_W'($past(step) + 1'b1));

  // R5
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> timer == reload_of($past(period), $past(shift)));

  // R5
  timer_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer != '0);

  // R4
  clear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_clear |=> step == '0);

  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> level == '0);

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !seq_clear) |=> (step == $past(step) && timer == $past(timer)));

  // R9
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !seq_clear) |=> (step == $past(step) && timer == $past(timer)));

  // R7
  shift_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift == '0 || shift == SH_W'(SHIFT_MID) || shift == SH_W'(SHIFT_HI)));

  // R6
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 || level == vol));

endmodule

bind pulse_tone_channel pulse_tone_channel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .enable    (enable),
  .halt      (halt),
  .seq_clear (seq_clear),
  .adv       (adv),
  .step      (step),
  .timer     (timer),
  .period    (period),
  .shift     (shift),
  .vol       (shape.vol),
  .level     (level)
);

// File: tb/tb_pulse_tone_channel.sv
module tb_pulse_tone_channel;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] level;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int tick_div = 1;
  bit tick_run = 1;
  int tcnt = 0;

  always #2 clk = ~clk;   // 250 MHz

  pulse_tone_channel dut (
    .clk, .rst_n, .tick, .wr_en, .wr_sel, .wr_data, .level
  );

  always @(negedge clk) begin
    if (!tick_run) begin
      tick <= 1'b0;
    end else begin
      tick <= (tcnt == 0);
      tcnt = (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // waits for level zero (want_hi=0) or nonzero (want_hi=1); returns 1 if seen
  task automatic wait_lvl(input bit want_hi, output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      if ((level != 0) == want_hi) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic measure(output int hi, output int lo, output int val);
    bit ok;
    hi = 0; lo = 0; val = 0;
    wait_lvl(0, ok);
    wait_lvl(1, ok);
    val = level;
    while (level != 0 && hi < 20000) begin hi++; @(negedge clk); end
    while (level == 0 && lo < 20000) begin lo++; @(negedge clk); end
  endtask

  function automatic int exp_reload(input int p, input int ctrl);
    int sh;
    sh = ctrl[2] ? 8 : (ctrl[1] ? 4 : 0);
    return (p >> sh) + 1;
  endfunction

  task automatic config_ch(input int ctrl, input int shape, input int p);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'(ctrl));
    wr(2'd0, 8'(shape));
    wr(2'd1, 8'(p & 255));
    wr(2'd2, 8'(8'h80 | ((p >> 8) & 15)));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi, lo, val, ref0, r;
    bit ok;
    int ctrls[4];
    int pers[4];
    ctrls = '{0, 2, 4, 6};
    pers  = '{5, 53, 1023, 1023};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset: output quiet
    chk("R1 reset level", level, 0);

    // R1 period defaults to 1: enable with only the shape written
    wr(2'd0, 8'h0F);
    chk("R4 disabled after shape write", level, 0);
    wr(2'd2, 8'h80);
    chk("R3 enable starts at step 0", level, 15);
    measure(hi, lo, val);
    chk("R1 reset period high", hi, 2);
    chk("R1 reset period low", lo, 30);

    // R5 R6 R7 sweep over duty and shift settings
    for (int c = 0; c < 4; c++) begin
      r = exp_reload(pers[c], ctrls[c]);
      for (int d = 0; d < 8; d++) begin
        config_ch(ctrls[c], (d << 4) | (d + 1), pers[c]);
        measure(hi, lo, val);
        chk($sformatf("R6 high c%0d d%0d", c, d), hi, (d + 1) * r);
        chk($sformatf("R5 R7 low c%0d d%0d", c, d), lo, (15 - d) * r);
        chk($sformatf("R2 volume c%0d d%0d", c, d), val, d + 1);
      end
    end

    // R9 half-rate tick doubles every run
    tick_div = 2;
    config_ch(0, (2 << 4) | 6, 5);
    measure(hi, lo, val);
    chk("R9 half tick high", hi, 2 * 3 * 6);
    chk("R9 half tick low", lo, 2 * 13 * 6);
    tick_div = 1;

    // R9 tick held low freezes output
    config_ch(0, (3 << 4) | 9, 5);
    tick_run = 0;
    @(negedge clk);
    ref0 = level;
    r = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (level != ref0) r++; end
    chk("R9 no tick no change", r, 0);
    tick_run = 1;

    // R8 halt while low
    wait_lvl(0, ok);
    wr(2'd3, 8'h01);
    ref0 = level;
    r = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (level != ref0) r++; end
    chk("R8 halt holds low", r, 0);
    wr(2'd3, 8'h00);
    wait_lvl(1, ok);
    chk("R8 resumes after halt", int'(ok), 1);
    // R8 halt while high
    wr(2'd3, 8'h01);
    ref0 = level;
    r = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (level != ref0) r++; end
    chk("R8 halt holds level", r, 0);
    // R7 halt bit with shift bits: still halted, bit 0 decoded alone
    wr(2'd3, 8'h07);
    r = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (level != ref0) r++; end
    chk("R7 halt with shift bits", r, 0);
    wr(2'd3, 8'h00);

    // R4 disable clears the step
    config_ch(0, 12, 5);
    wait_lvl(0, ok);
    wr(2'd2, 8'h00);
    chk("R4 disabled level", level, 0);
    repeat (20) @(negedge clk);
    chk("R4 stays quiet", level, 0);
    wr(2'd2, 8'h80);
    chk("R4 re-enable at step 0", level, 12);

    // R6 R2 duty-ignore flag forces constant level
    config_ch(0, 8'h80 | (5 << 4) | 7, 5);
    r = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (level != 7) r++; end
    chk("R6 R2 ignore flag constant", r, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule